// File: doc/BRIEF.md
# Receive Buffer Flow-Control Trigger

This block sits beside a MAC receive path and watches how much room is left in the receive packet buffer. When the link runs half duplex and the free space drops under a programmable high-water mark, it raises a jam request. The transmit side uses that request to apply back-pressure to the sender. When the link runs full duplex it never jams. Instead it turns software commands into requests for pause frames, whose time field is either all zeros or all ones.

Software sets two command bits: one asks for a zero-time pause and the other for a maximum-time pause. Each bit stays set and can be read back until the transmit side acknowledges that the matching pause frame has gone out, and then it clears itself. The frame builder and the transmit arbiter lie outside this block. They see only a request line, a 16-bit time value and an acknowledge pulse.

Top module: `rx_flow_trigger`

## Requirements
- R1: After a synchronous reset, `jam_req`, `pause_req`, `force_zero_q` and `force_max_q` are 0, and the high-water mark is 3, which means 3072 bytes of free space.
- R2: In half duplex (`full_duplex`=0), `jam_req` is 1 in the cycle after a clock edge at which `free_bytes` is below the mark times 1024.
- R3: `jam_req` drops in the cycle after a clock edge at which `free_bytes` is equal to or above the mark times 1024. There is no hysteresis.
- R4: While `full_duplex`=1, `jam_req` is 0 one cycle later, whatever the free space is.
- R5: A clock edge with `thr_wr`=1 loads `thr_wdata` as the mark, in 1 KB units. A mark larger than `BUF_BYTES`/1024 acts as `BUF_BYTES`/1024.
- R6: A clock edge with `force_wr`=1 and `force_max_in`=1 sets `force_max_q`. While that bit is set and `full_duplex`=1, `pause_req`=1 and `pause_time`=16'hFFFF.
- R7: A clock edge with `force_wr`=1 and `force_zero_in`=1 sets `force_zero_q`. When it is the only bit set and `full_duplex`=1, `pause_req`=1 and `pause_time`=16'h0000.
- R8: A clock edge with `pause_ack`=1 while `pause_req`=1 clears the bit being served, so each command bit clears itself.
- R9: When both bits are set, the 16'hFFFF request is served first and the 16'h0000 request follows it.
- R10: In half duplex, `pause_req` is 0 and any set command bits stay pending.
- R11: `pause_ack` while `pause_req`=0 changes no command bit.
- R12: A write with `force_wr`=1 whose data bits are 0 clears no command bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_bytes | input | FREE_W | Free bytes in the receive buffer |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| thr_wr | input | 1 | Write strobe for the high-water mark |
| thr_wdata | input | THR_W | New mark, in 1 KB units |
| force_wr | input | 1 | Write strobe for the command bits |
| force_zero_in | input | 1 | 1 sets the zero-time pause command |
| force_max_in | input | 1 | 1 sets the maximum-time pause command |
| pause_ack | input | 1 | The requested pause frame has been sent |
| jam_req | output | 1 | Back-pressure jam request |
| pause_req | output | 1 | Pause frame request |
| pause_time | output | 16 | Time field for the requested pause |
| force_zero_q | output | 1 | Readback of the zero-time command |
| force_max_q | output | 1 | Readback of the maximum-time command |

## Verification
If the high-water register holds a wrong value, `jam_req` flips one cycle after the first half-duplex edge at which the free space crosses the wrong boundary. The bench therefore sweeps free space to exactly the mark and to one below it. If a command bit is lost or cleared wrongly, the fault shows on the readback outputs in the same cycle, and on `pause_req` and `pause_time` in the same cycle once the link is full duplex. A wrong service order shows as an acknowledge that clears the zero-time bit while the maximum-time bit is still set.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef struct packed {
        logic zero;
        logic max;
    } force_bits_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ZERO = 2'd1,
        SEL_MAX  = 2'd2
    } pause_sel_e;

    localparam logic [15:0] PT_ZERO = 16'h0000;
    localparam logic [15:0] PT_MAX  = 16'hFFFF;
    localparam int          KB_BYTES = 1024;

    // maximum time has priority over zero time
    function automatic pause_sel_e pick_pause(input force_bits_t f);
        if (f.max)       return SEL_MAX;
        else if (f.zero) return SEL_ZERO;
        else             return SEL_NONE;
    endfunction

    function automatic logic [15:0] sel_time(input pause_sel_e s);
        return (s == SEL_MAX) ? PT_MAX : PT_ZERO;
    endfunction

endpackage

// File: rtl/rxfc_thresh.sv
module rxfc_thresh
    import rxfc_pkg::*;
#(
    parameter int BUF_BYTES = 8192,
    parameter int THR_W     = 4,
    parameter int THR_RST   = 3,
    parameter int FREE_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_wr,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic              full_duplex,
    output logic              jam_req
);
    localparam int BUF_KB = BUF_BYTES / KB_BYTES;

    logic [THR_W-1:0]  thr_q;
    logic [FREE_W-1:0] limit_bytes;
    int                eff_kb;

    always_ff @(posedge clk) begin
        if (rst)         thr_q <= THR_W'(THR_RST);
        else if (thr_wr) thr_q <= thr_wdata;
    end

    always_comb begin
        eff_kb      = (int'(thr_q) > BUF_KB) ? BUF_KB : int'(thr_q);
        limit_bytes = FREE_W'(eff_kb * KB_BYTES);
    end

    always_ff @(posedge clk) begin
        if (rst) jam_req <= 1'b0;
        else     jam_req <= !full_duplex && (free_bytes < limit_bytes);
    end

endmodule

// File: rtl/rxfc_force.sv
module rxfc_force
    import rxfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        force_wr,
    input  logic        force_zero_in,
    input  logic        force_max_in,
    input  logic        full_duplex,
    input  logic        pause_ack,
    output logic        pause_req,
    output logic [15:0] pause_time,
    output force_bits_t force_q
);
    pause_sel_e  sel;
    force_bits_t clr, set, nxt;

    always_comb begin
        sel        = pick_pause(force_q);
        pause_req  = full_duplex && (sel != SEL_NONE);
        pause_time = sel_time(sel);
        clr.max    = pause_req && pause_ack && (sel == SEL_MAX);
        clr.zero   = pause_req && pause_ack && (sel == SEL_ZERO);
        set.max    = force_wr && force_max_in;
        set.zero   = force_wr && force_zero_in;
        nxt        = (force_q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (rst) force_q <= '0;
        else     force_q <= nxt;
    end

endmodule

// File: rtl/rx_flow_trigger.sv
module rx_flow_trigger
    import rxfc_pkg::*;
#(
    parameter int BUF_BYTES = 8192,
    parameter int THR_W     = 4,
    parameter int THR_RST   = 3,
    parameter int FREE_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic              full_duplex,
    input  logic              thr_wr,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic              force_wr,
    input  logic              force_zero_in,
    input  logic              force_max_in,
    input  logic              pause_ack,
    output logic              jam_req,
    output logic              pause_req,
    output logic [15:0]       pause_time,
    output logic              force_zero_q,
    output logic              force_max_q
);
    force_bits_t fq;

    rxfc_thresh #(
        .BUF_BYTES(BUF_BYTES), .THR_W(THR_W), .THR_RST(THR_RST), .FREE_W(FREE_W)
    ) u_thresh (
        .clk(clk), .rst(rst), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .free_bytes(free_bytes), .full_duplex(full_duplex), .jam_req(jam_req)
    );

    rxfc_force u_force (
        .clk(clk), .rst(rst), .force_wr(force_wr),
        .force_zero_in(force_zero_in), .force_max_in(force_max_in),
        .full_duplex(full_duplex), .pause_ack(pause_ack),
        .pause_req(pause_req), .pause_time(pause_time), .force_q(fq)
    );

    assign force_zero_q = fq.zero;
    assign force_max_q  = fq.max;

endmodule

// File: rtl/rxfc_chk.sv
module rxfc_chk (
    input logic        clk,
    input logic        rst,
    input logic        full_duplex,
    input logic        force_wr,
    input logic        force_zero_in,
    input logic        force_max_in,
    input logic        pause_ack,
    input logic        jam_req,
    input logic        pause_req,
    input logic [15:0] pause_time,
    input logic        force_zero_q,
    input logic        force_max_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!jam_req && !force_zero_q && !force_max_q));

    // R4
    no_jam_fdx_chk: assert property (@(posedge clk) disable iff (rst)
        full_duplex |=> !jam_req);

    // R10
    pause_only_fdx_chk: assert property (@(posedge clk) disable iff (rst)
        pause_req |-> full_duplex);

    // R6
    max_time_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_req && force_max_q) |-> (pause_time == 16'hFFFF));

    // R8
    max_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_req && pause_ack && force_max_q && !(force_wr && force_max_in))
        |=> !force_max_q);

    // R9
    zero_waits_chk: assert property (@(posedge clk) disable iff (rst)
        (pause_ack && force_max_q && force_zero_q) |=> force_zero_q);

    // R11
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!pause_req && !force_wr) |=> ($stable(force_zero_q) && $stable(force_max_q)));

endmodule

bind rx_flow_trigger rxfc_chk u_chk (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .force_wr(force_wr),
    .force_zero_in(force_zero_in), .force_max_in(force_max_in),
    .pause_ack(pause_ack), .jam_req(jam_req), .pause_req(pause_req),
    .pause_time(pause_time), .force_zero_q(force_zero_q), .force_max_q(force_max_q)
);

// File: tb/sim_rx_flow_trigger.sv
module sim_rx_flow_trigger;
    localparam int PERIOD    = 10;
    localparam int BUF_BYTES = 8192;
    localparam int BUF_KB    = BUF_BYTES / 1024;
    localparam int FREE_W    = $clog2(BUF_BYTES + 1);

    logic clk = 0, rst = 1;
    logic [FREE_W-1:0] free_bytes = '0;
    logic full_duplex = 0, thr_wr = 0, force_wr = 0;
    logic force_zero_in = 0, force_max_in = 0, pause_ack = 0;
    logic [3:0] thr_wdata = '0;
    logic jam_req, pause_req, force_zero_q, force_max_q;
    logic [15:0] pause_time;

    int vectors = 0, errors = 0;
    string phase = "R1";
    bit running = 0;

    // reference state
    int m_thr = 3;
    bit m_jam = 0, m_fz = 0, m_fm = 0;

    rx_flow_trigger #(.BUF_BYTES(BUF_BYTES)) u0 (
        .clk(clk), .rst(rst), .free_bytes(free_bytes), .full_duplex(full_duplex),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata), .force_wr(force_wr),
        .force_zero_in(force_zero_in), .force_max_in(force_max_in),
        .pause_ack(pause_ack), .jam_req(jam_req), .pause_req(pause_req),
        .pause_time(pause_time), .force_zero_q(force_zero_q), .force_max_q(force_max_q)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_thr = 3; m_jam = 0; m_fz = 0; m_fm = 0;
        end else begin
            int lim;
            bit nj, req;
            lim = ((m_thr > BUF_KB) ? BUF_KB : m_thr) * 1024;
            nj  = !full_duplex && (int'(free_bytes) < lim);
            req = full_duplex && (m_fz || m_fm);
            if (req && pause_ack) begin
                if (m_fm) m_fm = 0; else m_fz = 0;
            end
            if (force_wr && force_zero_in) m_fz = 1;
            if (force_wr && force_max_in)  m_fm = 1;
            if (thr_wr) m_thr = int'(thr_wdata);
            m_jam = nj;
        end
    end

    task automatic cmp(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            bit er;
            er = full_duplex && (m_fz || m_fm);
            cmp("jam_req", int'(jam_req), int'(m_jam));
            cmp("pause_req", int'(pause_req), int'(er));
            if (er) cmp("pause_time", int'(pause_time), m_fm ? 32'hFFFF : 0);
            cmp("force_zero_q", int'(force_zero_q), int'(m_fz));
            cmp("force_max_q", int'(force_max_q), int'(m_fm));
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_force(bit z, bit m);
        force_wr = 1; force_zero_in = z; force_max_in = m;
        tick();
        force_wr = 0; force_zero_in = 0; force_max_in = 0;
    endtask

    task automatic ack();
        pause_ack = 1; tick(); pause_ack = 0;
    endtask

    initial begin
        #(PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        free_bytes = FREE_W'(BUF_BYTES);
        tick(3);
        rst = 0;
        running = 1;
        phase = "R1"; tick(2);
        phase = "R2"; free_bytes = 4000; tick(2); free_bytes = 3071; tick(3);
        phase = "R3"; free_bytes = 3072; tick(2); free_bytes = 3071; tick(); free_bytes = 8000; tick(2);
        phase = "R5"; thr_wr = 1; thr_wdata = 5; tick(); thr_wr = 0;
        free_bytes = 5119; tick(2); free_bytes = 5120; tick(2);
        thr_wr = 1; thr_wdata = 15; tick(); thr_wr = 0;
        free_bytes = 8191; tick(2); free_bytes = 8192; tick(2);
        phase = "R4"; full_duplex = 1; free_bytes = 0; tick(3);
        phase = "R10"; full_duplex = 0; wr_force(0, 1); tick(2); ack(); tick();
        phase = "R6"; full_duplex = 1; tick(2);
        phase = "R8"; ack(); tick(2);
        phase = "R7"; wr_force(1, 0); tick(2); ack(); tick();
        phase = "R9"; wr_force(1, 1); tick(); ack(); tick(); ack(); tick(2);
        phase = "R11"; ack(); ack(); tick();
        phase = "R12"; wr_force(1, 0); wr_force(0, 0); tick(); full_duplex = 0; wr_force(0, 0); tick(); full_duplex = 1; ack(); tick();
        phase = "R2";
        for (int i = 0; i < 400; i++) begin
            free_bytes    = FREE_W'($urandom_range(0, BUF_BYTES));
            full_duplex   = 1'($urandom_range(0, 1));
            thr_wr        = ($urandom_range(0, 15) == 0);
            thr_wdata     = 4'($urandom_range(0, 15));
            force_wr      = ($urandom_range(0, 3) == 0);
            force_zero_in = 1'($urandom_range(0, 1));
            force_max_in  = 1'($urandom_range(0, 1));
            pause_ack     = 1'($urandom_range(0, 1));
            tick();
        end
        thr_wr = 0; force_wr = 0; pause_ack = 0;
        phase = "R1"; rst = 1; tick(); rst = 0; tick(2);
        running = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule